// File: doc/BRIEF.md
# Reconfigurable Dual-Half Timer with PWM and Toggle Outputs

This block is a 16-bit timer built from two 8-bit halves. Each half has its own 8-bit prescaler, driven by a shared clock-enable tick. A 2-bit mode field sets how the halves work together:

| Mode | Behaviour |
|------|-----------|
| 0 | Two independent 8-bit toggle timers. The upper half may count external events instead of prescaled ticks. |
| 1 | Two independent 8-bit PWM generators. |
| 2 | One cascaded 16-bit timer/counter with toggle outputs. |
| 3 | One 16-bit timer whose low byte also drives a PWM output. |

Software programs the block through a small write port. It sets the mode, the run bits, the prescaler reloads and two compare bytes. The compare bytes serve as periods, duties or the halves of a 16-bit match value, depending on the mode. Compare values go into shadow registers and reach the active copies only at the end of a period or when a stopped half is restarted. This keeps a running output free of glitches.

The block drives two output pins and two match flags. Each match flag is a one-cycle pulse.

Top module: `dual_tmr`

## Requirements
- R1: After reset both output pins and both match flags are 0. The mode is 0 and both halves are stopped.
- R2: Register map. A write to address 0 sets the mode in bits [1:0], run_lo in bit 2, run_hi in bit 3 and ext_sel in bit 4. Address 1 holds the low prescaler reload, address 2 the high prescaler reload, address 3 the low compare byte and address 4 the high compare byte.
- R3: In mode 0 each half counts from 0 up to its compare value C. It then clears, pulses its match flag for one cycle and inverts its output pin. Consecutive match pulses are therefore (P+1)*(C+1) counting ticks apart.
- R4: A prescaler with reload P passes one step per P+1 cycles in which tick is high. Cycles with tick low do not advance it.
- R5: In mode 0 with ext_sel set, the upper half counts rising edges of ext_in, which pass through a two-flop synchroniser, regardless of tick. C+1 edges give exactly one match.
- R6: In mode 1 each half counts freely through 256 steps. Its pin is high while the count is below the active duty and low otherwise. The match flag pulses when the count wraps to 0.
- R7: Compare bytes written while a half runs take effect only at that half's next match (mode 0) or wrap (mode 1). The period in progress completes with the old value.
- R8: In mode 2 the 16-bit count steps on the low prescaler, or on synchronised ext_in edges when ext_sel is set. At the value {cmp_hi,cmp_lo} it clears, pulses match_hi and inverts out_hi.
- R9: In mode 2, whenever the low count byte equals cmp_lo on a step, match_lo pulses and out_lo inverts. The 16-bit count is not cleared.
- R10: In mode 3 the low byte runs a 256-step PWM on out_lo with duty cmp_lo, and match_lo pulses at each low-byte wrap. The high byte advances on each wrap and matches at cmp_hi, clearing and toggling out_hi. The out_hi period is 256*(cmp_hi+1) steps.
- R11: Clearing a run bit freezes that half's prescaler and counter. Its pin keeps its level and its match flag stays 0. In modes 2 and 3, run_lo governs both halves.
- R12: A write to address 0 restarts each half that was stopped before the write. Its prescaler and count clear and its active compare loads from the shadow, so a PWM half raises its first wrap pulse 256 steps after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable feeding both prescalers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R2) |
| wr_data | input | 8 | Register write data |
| ext_in | input | 1 | External event input, asynchronous |
| out_lo | output | 1 | Low-half toggle or PWM pin |
| out_hi | output | 1 | High-half toggle or PWM pin |
| match_lo | output | 1 | Low-half match pulse |
| match_hi | output | 1 | High-half match pulse |

## Verification
A match flag and its toggled pin appear in the cycle after the clock edge that takes the final step of a period. A PWM pin follows the count with no extra register. An ext_in rise is counted on the third clock edge after it is first sampled. A control write restarts a stopped half on the edge that takes it.

The bench drives inputs and samples outputs on falling edges. It measures periods as cycle distances between consecutive match pulses, so fixed latencies cancel out. Duty is counted over exactly one period, starting at the wrap pulse. Only the restart test checks an absolute latency: 256 falling edges from the write to the first wrap pulse.

// File: rtl/dual_tmr.sv
module dual_tmr #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [HW-1:0] wr_data,
  input  logic          ext_in,
  output logic          out_lo,
  output logic          out_hi,
  output logic          match_lo,
  output logic          match_hi
);
  localparam logic [HW-1:0] TOP = '1;
  localparam logic [2:0] A_CTRL = 3'd0, A_PLO = 3'd1, A_PHI = 3'd2,
                         A_CLO = 3'd3, A_CHI = 3'd4;

  logic [1:0]    mode_q;
  logic          run_lo_q, run_hi_q, ext_sel_q;
  logic [HW-1:0] pre_lo_q, pre_hi_q, sh_lo, sh_hi, act_lo, act_hi;
  logic [HW-1:0] pc_lo, pc_hi, cnt_lo, cnt_hi;
  logic          tog_lo, tog_hi, m_lo, m_hi;
  logic [2:0]    sync_q;

  wire split     = ~mode_q[1];
  wire run_b     = split ? run_hi_q : run_lo_q;
  wire ext_rise  = sync_q[1] & ~sync_q[2];
  wire ctrl_wr   = wr_en && wr_addr == A_CTRL;
  wire restart_a = ctrl_wr && !run_lo_q;
  wire restart_b = ctrl_wr && !run_b;
  wire pstep_lo  = run_lo_q && tick && pc_lo == pre_lo_q;
  wire pstep_hi  = run_b && tick && pc_hi == pre_hi_q;
  wire st_lo     = (mode_q == 2'd2 && ext_sel_q) ? (run_lo_q && ext_rise) : pstep_lo;
  wire st_hi     = (mode_q == 2'd0 && ext_sel_q) ? (run_hi_q && ext_rise) : pstep_hi;
  wire full_hit  = {cnt_hi, cnt_lo} == {act_hi, act_lo};

  assign out_lo   = (mode_q == 2'd1 || mode_q == 2'd3) ? (cnt_lo < act_lo) : tog_lo;
  assign out_hi   = (mode_q == 2'd1) ? (cnt_hi < act_hi) : tog_hi;
  assign match_lo = m_lo;
  assign match_hi = m_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; run_lo_q <= 1'b0; run_hi_q <= 1'b0; ext_sel_q <= 1'b0;
      pre_lo_q <= '0; pre_hi_q <= '0; sh_lo <= '0; sh_hi <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          mode_q    <= wr_data[1:0];
          run_lo_q  <= wr_data[2];
          run_hi_q  <= wr_data[3];
          ext_sel_q <= wr_data[4];
        end
        A_PLO:   pre_lo_q <= wr_data;
        A_PHI:   pre_hi_q <= wr_data;
        A_CLO:   sh_lo    <= wr_data;
        A_CHI:   sh_hi    <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_lo <= '0; pc_hi <= '0;
    end else begin
      if (restart_a)               pc_lo <= '0;
      else if (run_lo_q && tick)   pc_lo <= (pc_lo == pre_lo_q) ? '0 : pc_lo + 1'b1;
      if (restart_b)               pc_hi <= '0;
      else if (run_b && tick)      pc_hi <= (pc_hi == pre_hi_q) ? '0 : pc_hi + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0; cnt_hi <= '0; act_lo <= '0; act_hi <= '0;
      tog_lo <= 1'b0; tog_hi <= 1'b0; m_lo <= 1'b0; m_hi <= 1'b0;
    end else begin
      m_lo <= 1'b0;
      m_hi <= 1'b0;
      case (mode_q)
        2'd0: begin
          if (st_lo) begin
            if (cnt_lo == act_lo) begin
              cnt_lo <= '0; act_lo <= sh_lo; tog_lo <= ~tog_lo; m_lo <= 1'b1;
            end else cnt_lo <= cnt_lo + 1'b1;
          end
          if (st_hi) begin
            if (cnt_hi == act_hi) begin
              cnt_hi <= '0; act_hi <= sh_hi; tog_hi <= ~tog_hi; m_hi <= 1'b1;
            end else cnt_hi <= cnt_hi + 1'b1;
          end
        end
        2'd1: begin
          if (st_lo) begin
            cnt_lo <= cnt_lo + 1'b1;
            if (cnt_lo == TOP) begin act_lo <= sh_lo; m_lo <= 1'b1; end
          end
          if (st_hi) begin
            cnt_hi <= cnt_hi + 1'b1;
            if (cnt_hi == TOP) begin act_hi <= sh_hi; m_hi <= 1'b1; end
          end
        end
        2'd2: begin
          if (st_lo) begin
            if (full_hit) begin
              {cnt_hi, cnt_lo} <= '0;
              act_lo <= sh_lo; act_hi <= sh_hi;
              tog_hi <= ~tog_hi; m_hi <= 1'b1;
            end else {cnt_hi, cnt_lo} <= {cnt_hi, cnt_lo} + 1'b1;
            if (cnt_lo == act_lo) begin tog_lo <= ~tog_lo; m_lo <= 1'b1; end
          end
        end
        default: begin
          if (st_lo) begin
            cnt_lo <= cnt_lo + 1'b1;
            if (cnt_lo == TOP) begin
              act_lo <= sh_lo; m_lo <= 1'b1;
              if (cnt_hi == act_hi) begin
                cnt_hi <= '0; act_hi <= sh_hi; tog_hi <= ~tog_hi; m_hi <= 1'b1;
              end else cnt_hi <= cnt_hi + 1'b1;
            end
          end
        end
      endcase
      if (restart_a) begin cnt_lo <= '0; act_lo <= sh_lo; end
      if (restart_b) begin cnt_hi <= '0; act_hi <= sh_hi; end
    end
  end
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    mode,
  input logic          run_lo,
  input logic          run_b,
  input logic          out_lo,
  input logic          out_hi,
  input logic          match_lo,
  input logic          match_hi,
  input logic [HW-1:0] cnt_lo,
  input logic [HW-1:0] cnt_hi
);
  p_toggle_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(mode) == 2'd0 && out_lo != $past(out_lo)) |-> match_lo);

  p_pwm_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) == 2'd1 && match_lo) |-> cnt_lo == '0);

  p_full_match_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd2 && match_hi) |-> (cnt_lo == '0 && cnt_hi == '0));

  p_no_match_lo_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_lo) |-> !match_lo);

  p_no_match_hi_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_b) |-> !match_hi);

  p_frozen_pin_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_lo) && !$past(wr_en)) |-> $stable(out_lo));

  p_frozen_pin_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_b) && !$past(wr_en)) |-> $stable(out_hi));
endmodule

bind dual_tmr dual_tmr_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode(mode_q),
  .run_lo(run_lo_q), .run_b(run_b), .out_lo(out_lo), .out_hi(out_hi),
  .match_lo(match_lo), .match_hi(match_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/test_dual_tmr.sv
module test_dual_tmr;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, ext_in = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic out_lo, out_hi, match_lo, match_hi;
  int checks = 0, errors = 0, tick_mode = 0;

  always #5 clk = ~clk;

  dual_tmr i_dual_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_in(ext_in), .out_lo(out_lo), .out_hi(out_hi),
    .match_lo(match_lo), .match_hi(match_hi)
  );

  always @(negedge clk) tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? ~tick : 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    return (w == 0) ? match_lo : match_hi;
  endfunction

  function automatic int period(input int p, input int c);
    return (p + 1) * (c + 1);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input int m, input bit rl, input bit rh, input bit ex);
    return {3'b000, ex, rh, rl, m[1:0]};
  endfunction

  task automatic cfg(input int m, input bit rl, input bit rh, input bit ex,
                     input int pl, input int ph, input int cl, input int chh);
    wr(3'd0, ctrl(m, 0, 0, ex));
    wr(3'd1, pl[7:0]);
    wr(3'd2, ph[7:0]);
    wr(3'd3, cl[7:0]);
    wr(3'd4, chh[7:0]);
    wr(3'd0, ctrl(m, rl, rh, ex));
  endtask

  task automatic gap_here(input int w, output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!pick(w) && g < 100000);
  endtask

  task automatic measure(input int w, output int g);
    int skip;
    gap_here(w, skip);
    gap_here(w, g);
  endtask

  task automatic high_count(input bit hi_pin, input int win, output int c);
    c = 0;
    for (int i = 0; i < win; i++) begin
      if (hi_pin ? out_hi : out_lo) c++;
      @(negedge clk);
    end
  endtask

  task automatic ext_pulse();
    ext_in = 1'b1; repeat (3) @(negedge clk);
    ext_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g, c, p, cc, ph, ch, hc, chg;
    logic o1, o2, ol, oh;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 out_lo", out_lo, 0); chk("R1 out_hi", out_hi, 0);
    chk("R1 match_lo", match_lo, 0); chk("R1 match_hi", match_hi, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 out_lo after release", out_lo, 0);

    // R3 R2 directed corner: C=0 P=0 pulses every cycle
    cfg(0, 1, 1, 0, 0, 0, 0, 0);
    measure(0, g); chk("R3 lo min period", g, 1);

    // R3 R4 random mode 0 periods
    for (int k = 0; k < 6; k++) begin
      p = $urandom % 4; cc = $urandom % 16; ph = $urandom % 4; ch = $urandom % 16;
      cfg(0, 1, 1, 0, p, ph, cc, ch);
      measure(0, g); chk("R3 R4 lo period", g, period(p, cc));
      o1 = out_lo; gap_here(0, g); o2 = out_lo;
      chk("R3 lo toggles", int'(o1 != o2), 1);
      measure(1, g); chk("R3 R4 hi period", g, period(ph, ch));
    end

    // R4 tick every other cycle doubles the period
    tick_mode = 1;
    cfg(0, 1, 0, 0, 2, 0, 5, 0);
    measure(0, g); chk("R4 gated tick", g, 2 * period(2, 5));
    tick_mode = 0;

    // R7 shadow load at match
    cfg(0, 1, 0, 0, 0, 0, 9, 0);
    measure(0, g); chk("R7 base period", g, 10);
    wr(3'd3, 8'd3);
    gap_here(0, g); chk("R7 old period completes", g, 10 - 2);
    gap_here(0, g); chk("R7 new period", g, 4);

    // R5 external events, tick held low
    tick_mode = 2;
    cfg(0, 0, 1, 1, 0, 0, 0, 4);
    oh = out_hi; hc = 0;
    for (int k = 0; k < 4; k++) begin
      ext_in = 1'b1; repeat (3) begin @(negedge clk); if (match_hi) hc++; end
      ext_in = 1'b0; repeat (3) begin @(negedge clk); if (match_hi) hc++; end
    end
    chk("R5 no match after C edges", hc, 0);
    ext_in = 1'b1; repeat (3) begin @(negedge clk); if (match_hi) hc++; end
    ext_in = 1'b0; repeat (3) begin @(negedge clk); if (match_hi) hc++; end
    chk("R5 one match after C+1 edges", hc, 1);
    chk("R5 out_hi toggled", int'(out_hi != oh), 1);
    tick_mode = 0;

    // R6 dual PWM
    cfg(1, 1, 1, 0, 0, 0, 100, 30);
    measure(0, g); chk("R6 lo period", g, 256);
    high_count(0, 256, c); chk("R6 lo duty", c, 100);
    measure(1, g); chk("R6 hi period", g, 256);
    high_count(1, 256, c); chk("R6 hi duty", c, 30);

    // R11 freeze
    repeat (77) @(negedge clk);
    wr(3'd0, ctrl(1, 0, 0, 0));
    ol = out_lo; oh = out_hi; hc = 0; chg = 0;
    repeat (600) begin
      @(negedge clk);
      if (match_lo || match_hi) hc++;
      if (out_lo != ol || out_hi != oh) chg++;
    end
    chk("R11 no match while stopped", hc, 0);
    chk("R11 pins hold while stopped", chg, 0);

    // R12 restart from a stopped half
    wr(3'd0, ctrl(1, 1, 0, 0));
    chk("R12 pwm high at count 0", out_lo, 1);
    gap_here(0, g); chk("R12 first wrap latency", g, 256);

    // R8 R9 cascaded 16-bit
    cfg(2, 1, 0, 0, 0, 0, 3, 2);
    measure(1, g); chk("R8 16-bit period", g, 516);
    gap_here(0, g); chk("R9 low match after clear", g, 4);
    gap_here(0, g); chk("R9 low match spacing", g, 256);

    // R10 16-bit with PWM low byte
    cfg(3, 1, 0, 0, 1, 0, 64, 2);
    measure(1, g); chk("R10 hi period", g, 1536);
    gap_here(0, g); chk("R10 lo wrap period", g, 512);
    high_count(0, 512, c); chk("R10 lo duty", c, 128);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule